// File: doc/BRIEF.md
# Gather-capable copy descriptor sequencer

The block takes 128-bit source descriptors for a copy engine and turns each one into a single memory read command. A command carries a 37-bit physical address, a virtual-channel select and a 16-bit byte length.

Descriptors with the gather flag set are chained into one destination transfer. The chain closes at the first descriptor whose gather flag is clear. The transfer attributes are taken from the first descriptor of a chain: source swap, destination swap, hash enable and a 16-bit metadata word. When the chain closes, the block reports the total length and these attributes on a one-cycle done pulse.

Read data comes back through a pass-through path. When the owning transfer asks for it, that path reverses the bytes of every 32-bit dword. A barrier flag holds a descriptor's command until all earlier reads have returned.

All three data interfaces use valid/ready handshakes.
- **Descriptor input:** a descriptor is taken on a cycle where `desc_valid` and `desc_ready` are both high. `desc_ready` is low while a command waits to be issued.
- **Command output:** `cmd_valid`, once high, stays high with stable fields until `cmd_ready` takes it.
- **Read-data path:** back-pressure from `rdo_ready` passes straight through to `rdi_ready`.

The done outputs are plain status pins with no handshake.

Top module: `copy_chain_seq`

## Requirements
- R1: The command address is {word1[4:0], word0[31:0]}, where word0 is descriptor bits [31:0] and word1 is bits [63:32]. `cmd_len` equals word1[31:16].
- R2: `cmd_vc` equals word1[7]. Bits word1[6:5] reach no output.
- R3: Each accepted descriptor yields exactly one command. While `cmd_valid` is high and `cmd_ready` is low, the command fields hold stable and `desc_ready` stays low.
- R4: A descriptor with word1[11] set keeps the chain open. The first descriptor with word1[11] clear closes the chain and adds its own length. `done_valid` pulses high for one cycle, in the cycle after the closing descriptor is accepted. `done_len` then shows the chain's summed length modulo 2^18.
- R5: The attributes come from the first descriptor of a chain: hash enable word1[8], source swap word1[9], destination swap word1[10] and metadata word2[15:0] (descriptor bits [79:64]). The same fields in later chain entries have no effect.
- R6: A descriptor with word1[13] set does not raise `cmd_valid` until every earlier command has returned its read data.
- R7: A read return beat with `rdi_last` high completes the oldest outstanding command.
  - Each beat passes from `rdi_*` to `rdo_*` unchanged in the same cycle.
  - When the source swap of that command's transfer is set, every dword has bytes 0↔3 and 1↔2 exchanged.
- R8: Reserved bits have no effect on the commands or the done report. These are word1[12], word1[15:14], word2[31:16], word3[19:0], and the ring id and loop count in word3[31:20].
- R9: After reset, `desc_ready` is 1, `cmd_valid` is 0 and `done_valid` is 0, and no chain is open.
- R10: At most OUTST (default 4) commands are outstanding. While that many are outstanding, `cmd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_data | input | 128 | Descriptor, word0 in bits [31:0] |
| cmd_valid | output | 1 | Read command offered |
| cmd_ready | input | 1 | Read command taken |
| cmd_addr | output | 37 | Read address |
| cmd_vc | output | 1 | Virtual channel select |
| cmd_len | output | 16 | Read length in bytes |
| rdi_valid | input | 1 | Read data beat from memory |
| rdi_ready | output | 1 | Read data beat accepted |
| rdi_data | input | 32 | Read data |
| rdi_last | input | 1 | Final beat of one command |
| rdo_valid | output | 1 | Read data beat onward |
| rdo_ready | input | 1 | Downstream accepts beat |
| rdo_data | output | 32 | Read data after optional swap |
| rdo_last | output | 1 | Final beat of one command |
| done_valid | output | 1 | One-cycle pulse, chain closed |
| done_len | output | 18 | Summed chain length |
| done_hash_en | output | 1 | Hash enable of the chain |
| done_src_swap | output | 1 | Source swap of the chain |
| done_dst_swap | output | 1 | Destination swap of the chain |
| done_meta | output | 16 | Metadata of the chain |

## Verification
A chain tracker stuck open or wrongly closed shows up one cycle after the closing descriptor is accepted: the done pulse is missing, arrives early, or carries the wrong summed length. A wrongly latched attribute shows in the done report, and also in the first read beat of a later chain entry, where the byte order comes out wrong at once. An outstanding count that drifts shows as a barrier or full stall that never releases, or releases too early. The bench sees either case through `cmd_valid` in the cycle after the matching read beat.

// File: rtl/copy_seq_pkg.sv
package copy_seq_pkg;
  localparam int DESC_W = 128;
  localparam int ADDR_W = 37;
  localparam int LEN_W  = 16;
  localparam int META_W = 16;
  localparam int SUM_W  = 18;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              vc;
    logic [LEN_W-1:0]  len;
    logic              hash_en;
    logic              src_swap;
    logic              dst_swap;
    logic              gather;
    logic              barrier;
    logic [META_W-1:0] meta;
  } desc_fields_t;

  typedef struct packed {
    logic              hash_en;
    logic              src_swap;
    logic              dst_swap;
    logic [META_W-1:0] meta;
  } xfer_attr_t;
endpackage

// File: rtl/desc_unpack.sv
module desc_unpack
  import copy_seq_pkg::*;
(
  input  logic [DESC_W-1:0] raw,
  output desc_fields_t      f
);
  localparam int W1 = 32;
  localparam int W2 = 64;
  localparam int HI_ADDR_BITS = ADDR_W - 32;

  logic [31:0] word0, word1, word2;
  assign word0 = raw[31:0];
  assign word1 = raw[W1 +: 32];
  assign word2 = raw[W2 +: 32];

  always_comb begin
    f          = '0;
    f.addr     = {word1[HI_ADDR_BITS-1:0], word0};
    f.vc       = word1[7];
    f.hash_en  = word1[8];
    f.src_swap = word1[9];
    f.dst_swap = word1[10];
    f.gather   = word1[11];
    f.barrier  = word1[13];
    f.len      = word1[31:16];
    f.meta     = word2[15:0];
  end

  // reserved, ring id and loop count are dropped
  logic unused_bits;
  assign unused_bits = ^{word1[6:5], word1[12], word1[15:14], word2[31:16], raw[127:96]};
endmodule

// File: rtl/chain_tracker.sv
module chain_tracker
  import copy_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  desc_fields_t f,
  output logic         eff_src_swap,
  output logic         done_valid,
  output logic [SUM_W-1:0] done_len,
  output xfer_attr_t   done_attr
);
  logic             open_q;
  logic [SUM_W-1:0] sum_q;
  xfer_attr_t       attr_q;
  logic             first;
  logic [SUM_W-1:0] sum_nx;
  xfer_attr_t       attr_in, attr_eff;

  always_comb begin
    first            = !open_q;
    attr_in.hash_en  = f.hash_en;
    attr_in.src_swap = f.src_swap;
    attr_in.dst_swap = f.dst_swap;
    attr_in.meta     = f.meta;
    attr_eff         = first ? attr_in : attr_q;
    sum_nx           = (first ? '0 : sum_q) + SUM_W'(f.len);
    eff_src_swap     = attr_eff.src_swap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      sum_q      <= '0;
      attr_q     <= '0;
      done_valid <= 1'b0;
      done_len   <= '0;
      done_attr  <= '0;
    end else begin
      done_valid <= 1'b0;
      if (accept) begin
        open_q <= f.gather;
        sum_q  <= sum_nx;
        if (first) attr_q <= attr_in;
        if (!f.gather) begin
          done_valid <= 1'b1;
          done_len   <= sum_nx;
          done_attr  <= attr_eff;
        end
      end
    end
  end

  AST_DONE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R4
endmodule

// File: rtl/rd_return_path.sv
module rd_return_path #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_swap,
  input  logic              rdi_valid,
  output logic              rdi_ready,
  input  logic [DATA_W-1:0] rdi_data,
  input  logic              rdi_last,
  output logic              rdo_valid,
  input  logic              rdo_ready,
  output logic [DATA_W-1:0] rdo_data,
  output logic              rdo_last,
  output logic              full,
  output logic              idle
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int DWORDS = DATA_W / 32;

  logic [DEPTH-1:0] swap_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;
  logic [DATA_W-1:0] swapped;

  assign rdi_ready = rdo_ready;
  assign rdo_valid = rdi_valid;
  assign rdo_last  = rdi_last;
  assign pop       = rdi_valid && rdo_ready && rdi_last;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign idle      = (cnt_q == '0);

  for (genvar d = 0; d < DWORDS; d++) begin : g_dw
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign swapped[32*d + 8*b +: 8] = rdi_data[32*d + 8*(3-b) +: 8];
    end
  end

  assign rdo_data = swap_q[rd_q] ? swapped : rdi_data;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swap_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) begin
        swap_q[wr_q] <= push_swap;
        wr_q         <= bump(wr_q);
      end
      if (pop) rd_q <= bump(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !idle); // R7
endmodule

// File: rtl/copy_chain_seq.sv
module copy_chain_seq
  import copy_seq_pkg::*;
#(
  parameter int OUTST  = 4,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 desc_valid,
  output logic                 desc_ready,
  input  logic [DESC_W-1:0]    desc_data,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic                 cmd_vc,
  output logic [LEN_W-1:0]     cmd_len,
  input  logic                 rdi_valid,
  output logic                 rdi_ready,
  input  logic [DATA_W-1:0]    rdi_data,
  input  logic                 rdi_last,
  output logic                 rdo_valid,
  input  logic                 rdo_ready,
  output logic [DATA_W-1:0]    rdo_data,
  output logic                 rdo_last,
  output logic                 done_valid,
  output logic [SUM_W-1:0]     done_len,
  output logic                 done_hash_en,
  output logic                 done_src_swap,
  output logic                 done_dst_swap,
  output logic [META_W-1:0]    done_meta
);
  desc_fields_t f;
  xfer_attr_t   d_attr;
  logic         accept, issue, eff_swap, rd_full, rd_idle;
  logic         pend_q, bar_q, swap_q;

  desc_unpack u_unpack (.raw(desc_data), .f(f));

  assign desc_ready = !pend_q;
  assign accept     = desc_valid && desc_ready;

  chain_tracker u_chain (
    .clk(clk), .rst_n(rst_n), .accept(accept), .f(f),
    .eff_src_swap(eff_swap), .done_valid(done_valid),
    .done_len(done_len), .done_attr(d_attr)
  );

  assign done_hash_en  = d_attr.hash_en;
  assign done_src_swap = d_attr.src_swap;
  assign done_dst_swap = d_attr.dst_swap;
  assign done_meta     = d_attr.meta;

  assign cmd_valid = pend_q && !rd_full && !(bar_q && !rd_idle);
  assign issue     = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      bar_q    <= 1'b0;
      swap_q   <= 1'b0;
      cmd_addr <= '0;
      cmd_vc   <= 1'b0;
      cmd_len  <= '0;
    end else if (accept) begin
      pend_q   <= 1'b1;
      bar_q    <= f.barrier;
      swap_q   <= eff_swap;
      cmd_addr <= f.addr;
      cmd_vc   <= f.vc;
      cmd_len  <= f.len;
    end else if (issue) begin
      pend_q <= 1'b0;
    end
  end

  rd_return_path #(.DEPTH(OUTST), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .push(issue), .push_swap(swap_q),
    .rdi_valid(rdi_valid), .rdi_ready(rdi_ready), .rdi_data(rdi_data),
    .rdi_last(rdi_last), .rdo_valid(rdo_valid), .rdo_ready(rdo_ready),
    .rdo_data(rdo_data), .rdo_last(rdo_last), .full(rd_full), .idle(rd_idle)
  );

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_vc)); // R3
  AST_BARRIER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && bar_q |-> rd_idle); // R6
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !desc_ready); // R3
endmodule

// File: tb/copy_chain_seq_tb.sv
module copy_chain_seq_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic         desc_valid = 0, cmd_ready = 1, rdi_valid = 0, rdi_last = 0, rdo_ready = 1;
  logic [127:0] desc_data = '0;
  logic [31:0]  rdi_data = '0;
  logic         desc_ready, cmd_valid, cmd_vc, rdi_ready, rdo_valid, rdo_last;
  logic [36:0]  cmd_addr;
  logic [15:0]  cmd_len, done_meta;
  logic [31:0]  rdo_data;
  logic         done_valid, done_hash_en, done_src_swap, done_dst_swap;
  logic [17:0]  done_len;

  copy_chain_seq u_dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_data(desc_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_vc(cmd_vc), .cmd_len(cmd_len),
    .rdi_valid(rdi_valid), .rdi_ready(rdi_ready), .rdi_data(rdi_data),
    .rdi_last(rdi_last), .rdo_valid(rdo_valid), .rdo_ready(rdo_ready),
    .rdo_data(rdo_data), .rdo_last(rdo_last), .done_valid(done_valid),
    .done_len(done_len), .done_hash_en(done_hash_en), .done_src_swap(done_src_swap),
    .done_dst_swap(done_dst_swap), .done_meta(done_meta)
  );

  int n_chk = 0, n_bad = 0;
  int cmd_cnt = 0, done_cnt = 0, outst = 0;
  logic [36:0] last_addr; logic last_vc; logic [15:0] last_len;
  logic [17:0] d_len; logic d_hash, d_ss, d_ds; logic [15:0] d_meta;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      cmd_cnt++; outst++;
      last_addr = cmd_addr; last_vc = cmd_vc; last_len = cmd_len;
    end
    if (rst_n && done_valid) begin
      done_cnt++;
      d_len = done_len; d_hash = done_hash_en; d_ss = done_src_swap;
      d_ds = done_dst_swap; d_meta = done_meta;
    end
  end

  function automatic logic [127:0] mk(input logic [31:0] lo, input logic [7:0] hi,
      input logic hash, input logic ss, input logic ds, input logic gat, input logic bar,
      input logic [15:0] len, input logic [15:0] meta, input logic rsv);
    logic [31:0] w1, w2, w3;
    w1 = {len, rsv ? 2'b11 : 2'b00, bar, rsv, gat, ds, ss, hash, hi};
    w2 = {rsv ? 16'hFFFF : 16'h0000, meta};
    w3 = rsv ? 32'hFFFF_FFFF : 32'h0;
    return {w3, w2, w1, lo};
  endfunction

  task automatic send(input logic [127:0] d);
    @(negedge clk);
    desc_valid = 1; desc_data = d;
    while (!desc_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    desc_valid = 0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic beat(input logic [31:0] data, input logic last, output logic [31:0] seen);
    @(negedge clk);
    rdi_valid = 1; rdi_data = data; rdi_last = last;
    #1 seen = rdo_data;
    @(posedge clk);
    if (last) outst--;
    #1 rdi_valid = 0; rdi_last = 0;
  endtask

  task automatic drain;
    logic [31:0] s;
    idle(1);
    while (outst > 0) begin
      beat(32'h0, 1'b1, s);
      idle(1);
    end
  endtask

  task automatic t_reset;
    chk("R9 desc_ready", desc_ready, 1);
    chk("R9 cmd_valid", cmd_valid, 0);
    chk("R9 done_valid", done_valid, 0);
  endtask

  task automatic t_single;
    int c0 = cmd_cnt, d0 = done_cnt;
    send(mk(32'hDEAD_BEEF, 8'h1A, 1, 0, 1, 0, 0, 16'h0123, 16'hA5A5, 0));
    chk("R4 done pulse", done_cnt - d0, 1);
    chk("R4 done_len", d_len, 18'h0123);
    chk("R5 attrs", {d_hash, d_ss, d_ds, d_meta}, {3'b101, 16'hA5A5});
    idle(2);
    chk("R3 one cmd", cmd_cnt - c0, 1);
    chk("R1 addr", last_addr, {5'h1A, 32'hDEAD_BEEF});
    chk("R1 len", last_len, 16'h0123);
    chk("R2 vc0", last_vc, 0);
    drain();
  endtask

  task automatic t_vc;
    send(mk(32'h0000_1000, 8'hE5, 0, 0, 0, 0, 0, 16'h10, 16'h0, 0));
    idle(2);
    chk("R2 vc1", last_vc, 1);
    chk("R2 addr drops bits 6:5", last_addr, {5'h05, 32'h0000_1000});
    drain();
  endtask

  task automatic t_gather;
    int d0 = done_cnt;
    logic [31:0] s;
    cmd_ready = 1;
    send(mk(32'h100, 8'h0, 1, 1, 0, 1, 0, 16'd100, 16'h1234, 0));
    send(mk(32'h200, 8'h0, 0, 0, 1, 1, 0, 16'd200, 16'h5678, 0));
    chk("R4 chain open no done", done_cnt - d0, 0);
    send(mk(32'h300, 8'h0, 0, 0, 1, 0, 0, 16'd300, 16'h9ABC, 0));
    chk("R4 chain closed", done_cnt - d0, 1);
    chk("R4 summed len", d_len, 18'd600);
    chk("R5 first attrs", {d_hash, d_ss, d_ds, d_meta}, {3'b110, 16'h1234});
    idle(2);
    beat(32'h1122_3344, 1, s);
    chk("R7 swap entry 1", s, 32'h4433_2211);
    beat(32'hAABB_CCDD, 1, s);
    chk("R5 later entry inherits swap", s, 32'hDDCC_BBAA);
    beat(32'h0102_0304, 1, s);
    chk("R7 swap entry 3", s, 32'h0403_0201);
    drain();
  endtask

  task automatic t_noswap;
    logic [31:0] s;
    send(mk(32'h400, 8'h0, 0, 0, 0, 0, 0, 16'd4, 16'h0, 0));
    idle(2);
    beat(32'h1122_3344, 1, s);
    chk("R7 pass-through", s, 32'h1122_3344);
    drain();
  endtask

  task automatic t_reserved;
    int d0 = done_cnt;
    send(mk(32'h0BAD_F00D, 8'h03, 0, 1, 0, 0, 0, 16'h0777, 16'h4242, 1));
    chk("R8 done", {d_len, d_hash, d_ss, d_ds, d_meta}, {18'h0777, 3'b010, 16'h4242});
    chk("R8 one done", done_cnt - d0, 1);
    idle(2);
    chk("R8 cmd", {last_addr, last_vc, last_len}, {5'h03, 32'h0BAD_F00D, 1'b0, 16'h0777});
    drain();
  endtask

  task automatic t_barrier;
    int c0;
    logic [31:0] s;
    send(mk(32'h500, 8'h0, 0, 0, 0, 0, 0, 16'd8, 16'h0, 0));
    idle(2);
    c0 = cmd_cnt;
    send(mk(32'h600, 8'h0, 0, 0, 0, 0, 1, 16'd8, 16'h0, 0));
    idle(3);
    chk("R6 withheld", cmd_valid, 0);
    chk("R6 no cmd", cmd_cnt - c0, 0);
    beat(32'h0, 1, s);
    idle(1);
    chk("R6 released", cmd_cnt - c0, 1);
    chk("R6 addr", last_addr, 37'h600);
    drain();
  endtask

  task automatic t_backpressure;
    logic [36:0] a;
    cmd_ready = 0;
    send(mk(32'h700, 8'h0, 0, 0, 0, 0, 0, 16'd3, 16'h0, 0));
    idle(3);
    a = cmd_addr;
    chk("R3 held valid", cmd_valid, 1);
    chk("R3 desc blocked", desc_ready, 0);
    chk("R3 addr", a, 37'h700);
    @(negedge clk); cmd_ready = 1;
    idle(1);
    chk("R3 taken", {cmd_valid, desc_ready}, 2'b01);
    drain();
  endtask

  task automatic t_full;
    int c0 = cmd_cnt;
    logic [31:0] s;
    for (int i = 0; i < 4; i++) send(mk(32'h800 + i, 8'h0, 0, 0, 0, 0, 0, 16'd1, 16'h0, 0));
    send(mk(32'h900, 8'h0, 0, 0, 0, 0, 0, 16'd1, 16'h0, 0));
    idle(3);
    chk("R10 four issued", cmd_cnt - c0, 4);
    chk("R10 fifth withheld", cmd_valid, 0);
    beat(32'h0, 1, s);
    idle(1);
    chk("R10 fifth issued", cmd_cnt - c0, 5);
    drain();
  endtask

  task automatic t_wrap;
    int d0 = done_cnt;
    for (int i = 0; i < 4; i++) send(mk(32'hA00, 8'h0, 0, 0, 0, 1, 0, 16'hFFFF, 16'h0, 0));
    send(mk(32'hB00, 8'h0, 0, 0, 0, 0, 0, 16'hFFFF, 16'h0, 0));
    chk("R4 wrap done", done_cnt - d0, 1);
    chk("R4 wrap len", d_len, 18'd65531);
    drain();
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    t_reset();
    t_single();
    t_vc();
    t_gather();
    t_noswap();
    t_reserved();
    t_barrier();
    t_backpressure();
    t_full();
    t_wrap();
    idle(2);
    summary();
  end
endmodule